// File: doc/BRIEF.md
# Round-Robin Address-Space ID Allocator

This block hands out address-space identifiers to newly created address spaces and takes them back when those spaces are torn down. Identifiers come from a current range and are issued in ascending round-robin order, with ID 0 held back for the privileged context. A bitmap records which identifiers are live. Releasing an identifier clears its bit but does not trigger any translation purge. Stale translations are dealt with in bulk: when the range runs dry, the block raises a full TLB flush request and waits for the acknowledge. It then scans the bitmap, starting at the wrap point, to find the longest circular run of identifiers that are not in use, and that run becomes the new range.

A separate combinational port builds the value that is loaded into a region register. That value is an identifier shifted up by three bit positions, with the 3-bit region number in the low bits. The region-register width `RID_W` may be anything from 18 to 24 bits, so the identifier field in it is `RID_W-3` bits wide. The allocator's own identifier width `ASID_W` is a separate parameter and must not exceed that field width.

Top module: `asid_rr_alloc`

## Requirements
- R1: ID 0 is never granted. A release request naming ID 0 is rejected.
- R2: After reset the range is every nonzero ID, and the cursor starts at 1. Grants taken from one range are consecutive IDs. After ID 2^ASID_W-1 the next ID is 1, because 0 is skipped.
- R3: Granting the last ID of the range makes `flush_req` go high at the next clock edge. `flush_req` stays high until a cycle with `flush_ack` high. `alloc_ready` stays low from the flush request until the scan that follows it has finished.
- R4: After the acknowledge, the block scans the 2^ASID_W-1 nonzero IDs, one per cycle. The scan starts at the ID after the last one granted. It picks the longest circular run of IDs that are not live, and a run may cross from the top ID to 1. When two runs tie, the first run found wins. Grants then continue from the first ID of the chosen run, and no ID in that run is live.
- R5: Releasing a live ID clears it without any flush. That ID is granted again only after a later range choice has included it.
- R6: A release of an ID that is not live, including ID 0, changes no state. It is flagged by a one-cycle `free_bad` pulse one cycle after the request.
- R7: Suppose an allocation is accepted while the range is empty. If every nonzero ID is live, the response carries `alloc_err`=1. Otherwise the block holds the request, runs a flush and a scan, and then grants the first ID of the new range.
- R8: `rv_value` equals `rv_id` times 8 plus `rv_vrn`, with `rv_vrn` in bits 2:0. It is `RID_W` bits wide.
- R9: `alloc_req` is taken in a cycle in which `alloc_ready` is high. When the range is not empty, or when every ID is live, `alloc_vld` pulses for one cycle at the next edge, together with `alloc_id` and `alloc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | One-cycle allocation request |
| alloc_ready | output | 1 | Allocation requests are accepted |
| alloc_vld | output | 1 | Allocation response strobe |
| alloc_id | output | ASID_W | Granted identifier |
| alloc_err | output | 1 | No identifier could be granted |
| free_req | input | 1 | Release request |
| free_id | input | ASID_W | Identifier to release |
| free_bad | output | 1 | The previous release was rejected |
| flush_req | output | 1 | Full TLB flush requested |
| flush_ack | input | 1 | Flush completed |
| rv_id | input | RID_W-3 | Identifier for region value |
| rv_vrn | input | 3 | Region number |
| rv_value | output | RID_W | Region-register value |

## Verification
The bench builds the block with `ASID_W`=3, which gives seven usable identifiers, and `RID_W`=18. With that small space, a few dozen grants reach every corner case. Those include repeated exhaustion flushes, a scan that finds the space full, the error response, a pending request that waits through a flush, a run that wraps from 7 to 1, and a tie between two equal runs. The 18-bit region width exercises the identifier field of the region value at its narrowest legal size.

// File: rtl/asid_alloc_pkg.sv
package asid_alloc_pkg;

  typedef enum logic [1:0] {
    ST_SERVE = 2'd0,
    ST_FLUSH = 2'd1,
    ST_SCAN  = 2'd2
  } alloc_state_e;

  // Round-robin successor over 1..top; ID 0 is skipped.
  function automatic int unsigned rr_step(int unsigned id, int unsigned top);
    return (id >= top) ? 1 : id + 1;
  endfunction

endpackage

// File: rtl/asid_live_map.sv
module asid_live_map #(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ASID_W-1:0] set_id,
  input  logic              clr_en,
  input  logic [ASID_W-1:0] clr_id,
  input  logic [ASID_W-1:0] qa_id,
  output logic              qa_live,
  input  logic [ASID_W-1:0] qb_id,
  output logic              qb_live,
  output logic [ASID_W-1:0] live_cnt
);
  localparam int NUM_IDS = 1 << ASID_W;

  logic live_q [NUM_IDS];
  logic [ASID_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     live_q[g] <= 1'b0;
      else if (set_en && set_id == ASID_W'(g))        live_q[g] <= 1'b1;
      else if (clr_en && clr_id == ASID_W'(g))        live_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + ASID_W'(set_en) - ASID_W'(clr_en);
  end

  assign qa_live  = live_q[qa_id];
  assign qb_live  = live_q[qb_id];
  assign live_cnt = cnt_q;
endmodule

// File: rtl/asid_run_scan.sv
module asid_run_scan
  import asid_alloc_pkg::*;
#(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ASID_W-1:0] start_id,
  output logic [ASID_W-1:0] cur_id,
  input  logic              cur_live,
  output logic              busy,
  output logic              done,
  output logic [ASID_W-1:0] best_id,
  output logic [ASID_W-1:0] best_len
);
  localparam int unsigned TOP_ID = (1 << ASID_W) - 1;

  logic              busy_q, done_q;
  logic [ASID_W-1:0] pos_q, cur_q, run_id_q, run_len_q, best_id_q, best_len_q;
  logic [ASID_W-1:0] run_len_nx, run_id_nx;

  always_comb begin
    run_len_nx = cur_live ? '0 : run_len_q + ASID_W'(1);
    run_id_nx  = (run_len_q == '0) ? cur_q : run_id_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      pos_q      <= '0;
      cur_q      <= ASID_W'(1);
      run_id_q   <= ASID_W'(1);
      run_len_q  <= '0;
      best_id_q  <= ASID_W'(1);
      best_len_q <= '0;
    end else if (start) begin
      busy_q     <= 1'b1;
      done_q     <= 1'b0;
      pos_q      <= ASID_W'(TOP_ID);
      cur_q      <= start_id;
      run_id_q   <= start_id;
      run_len_q  <= '0;
      best_id_q  <= start_id;
      best_len_q <= '0;
    end else if (busy_q) begin
      run_len_q <= run_len_nx;
      run_id_q  <= run_id_nx;
      if (!cur_live && run_len_nx > best_len_q) begin
        best_id_q  <= run_id_nx;
        best_len_q <= run_len_nx;
      end
      cur_q <= ASID_W'(rr_step(32'(cur_q), TOP_ID));
      pos_q <= pos_q - ASID_W'(1);
      if (pos_q == ASID_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign cur_id   = cur_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign best_id  = best_id_q;
  assign best_len = best_len_q;
endmodule

// File: rtl/asid_region_fmt.sv
module asid_region_fmt #(
  parameter int RID_W = 18,
  parameter int VRN_W = 3
) (
  input  logic [RID_W-VRN_W-1:0] id,
  input  logic [VRN_W-1:0]       vrn,
  output logic [RID_W-1:0]       value
);
  assign value = {id, vrn};
endmodule

// File: rtl/asid_rr_alloc.sv
module asid_rr_alloc
  import asid_alloc_pkg::*;
#(
  parameter int RID_W  = 18,
  parameter int ASID_W = 8,
  parameter int VRN_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_req,
  output logic                   alloc_ready,
  output logic                   alloc_vld,
  output logic [ASID_W-1:0]      alloc_id,
  output logic                   alloc_err,
  input  logic                   free_req,
  input  logic [ASID_W-1:0]      free_id,
  output logic                   free_bad,
  output logic                   flush_req,
  input  logic                   flush_ack,
  input  logic [RID_W-VRN_W-1:0] rv_id,
  input  logic [VRN_W-1:0]       rv_vrn,
  output logic [RID_W-1:0]       rv_value
);
  localparam int unsigned TOP_ID = (1 << ASID_W) - 1;

  alloc_state_e      state_q, state_d;
  logic [ASID_W-1:0] cursor_q, cursor_d, remain_q, remain_d;
  logic              pend_q, pend_d;
  logic              vld_q, err_q, bad_q;
  logic [ASID_W-1:0] id_q;

  // Named internal events, observed by the bound checker.
  logic              grant_fire, err_fire, scan_go, free_ok, live_full, grant_clash;
  logic [ASID_W-1:0] grant_id;

  logic              qa_live, qb_live, scan_busy, scan_done;
  logic [ASID_W-1:0] live_cnt, scan_cur, best_id, best_len, qb_id;

  assign alloc_ready = (state_q == ST_SERVE);
  assign flush_req   = (state_q == ST_FLUSH);
  assign live_full   = (live_cnt == ASID_W'(TOP_ID));
  assign free_ok     = free_req && (free_id != '0) && qa_live;
  assign qb_id       = scan_busy ? scan_cur : grant_id;
  assign grant_clash = grant_fire && qb_live;

  asid_live_map #(.ASID_W(ASID_W)) map_i (
    .clk(clk), .rst_n(rst_n),
    .set_en(grant_fire), .set_id(grant_id),
    .clr_en(free_ok), .clr_id(free_id),
    .qa_id(free_id), .qa_live(qa_live),
    .qb_id(qb_id), .qb_live(qb_live),
    .live_cnt(live_cnt)
  );

  asid_run_scan #(.ASID_W(ASID_W)) scan_i (
    .clk(clk), .rst_n(rst_n),
    .start(scan_go), .start_id(cursor_q),
    .cur_id(scan_cur), .cur_live(qb_live),
    .busy(scan_busy), .done(scan_done),
    .best_id(best_id), .best_len(best_len)
  );

  asid_region_fmt #(.RID_W(RID_W), .VRN_W(VRN_W)) fmt_i (
    .id(rv_id), .vrn(rv_vrn), .value(rv_value)
  );

  always_comb begin
    state_d    = state_q;
    cursor_d   = cursor_q;
    remain_d   = remain_q;
    pend_d     = pend_q;
    grant_fire = 1'b0;
    grant_id   = cursor_q;
    err_fire   = 1'b0;
    scan_go    = 1'b0;
    case (state_q)
      ST_SERVE: begin
        if (alloc_req) begin
          if (remain_q != '0) begin
            grant_fire = 1'b1;
            cursor_d   = ASID_W'(rr_step(32'(cursor_q), TOP_ID));
            remain_d   = remain_q - ASID_W'(1);
            if (remain_q == ASID_W'(1)) state_d = ST_FLUSH;
          end else if (live_full) begin
            err_fire = 1'b1;
          end else begin
            pend_d  = 1'b1;
            state_d = ST_FLUSH;
          end
        end
      end
      ST_FLUSH: begin
        if (flush_ack) begin
          state_d = ST_SCAN;
          scan_go = 1'b1;
        end
      end
      ST_SCAN: begin
        if (scan_done) begin
          cursor_d = best_id;
          remain_d = best_len;
          state_d  = ST_SERVE;
          if (pend_q) begin
            pend_d = 1'b0;
            if (best_len == '0) begin
              err_fire = 1'b1;
            end else begin
              grant_fire = 1'b1;
              grant_id   = best_id;
              cursor_d   = ASID_W'(rr_step(32'(best_id), TOP_ID));
              remain_d   = best_len - ASID_W'(1);
              if (best_len == ASID_W'(1)) state_d = ST_FLUSH;
            end
          end
        end
      end
      default: state_d = ST_SERVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SERVE;
      cursor_q <= ASID_W'(1);
      remain_q <= ASID_W'(TOP_ID);
      pend_q   <= 1'b0;
      vld_q    <= 1'b0;
      err_q    <= 1'b0;
      id_q     <= '0;
      bad_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cursor_q <= cursor_d;
      remain_q <= remain_d;
      pend_q   <= pend_d;
      vld_q    <= grant_fire || err_fire;
      err_q    <= err_fire;
      id_q     <= grant_fire ? grant_id : '0;
      bad_q    <= free_req && !free_ok;
    end
  end

  assign alloc_vld = vld_q;
  assign alloc_err = err_q;
  assign alloc_id  = id_q;
  assign free_bad  = bad_q;
endmodule

// File: rtl/asid_rr_alloc_chk.sv
module asid_rr_alloc_chk #(
  parameter int ASID_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_vld,
  input logic              alloc_err,
  input logic [ASID_W-1:0] alloc_id,
  input logic              flush_req,
  input logic              flush_ack,
  input logic              free_req,
  input logic [ASID_W-1:0] free_id,
  input logic              free_bad,
  input logic              grant_fire,
  input logic              grant_clash,
  input logic              live_full
);
  // R1
  zero_never_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld && !alloc_err |-> alloc_id != '0);

  // R3
  flush_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req);

  // R4
  grant_not_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> !grant_clash);

  // R6
  zero_release_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_req && free_id == '0 |=> free_bad);

  // R7
  err_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld && alloc_err |-> $past(live_full));
endmodule

bind asid_rr_alloc asid_rr_alloc_chk #(.ASID_W(ASID_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .alloc_vld(alloc_vld), .alloc_err(alloc_err), .alloc_id(alloc_id),
  .flush_req(flush_req), .flush_ack(flush_ack),
  .free_req(free_req), .free_id(free_id), .free_bad(free_bad),
  .grant_fire(grant_fire), .grant_clash(grant_clash), .live_full(live_full)
);

// File: tb/asid_rr_alloc_tb_top.sv
`timescale 1ns/1ps
module asid_rr_alloc_tb_top;
  localparam int RID_W   = 18;
  localparam int ASID_W  = 3;
  localparam int VRN_W   = 3;
  localparam int FIELD_W = RID_W - VRN_W;
  localparam int NVEC    = 34;

  // {op[3:0], arg[7:0], exp[7:0]}; op 0 alloc (next-cycle response), 3 alloc (may wait),
  // 1 release (exp = expected free_bad), 2 flush-count check (arg = count); exp FF = error.
  localparam logic [19:0] VEC [0:NVEC-1] = '{
    20'h0_00_01, 20'h0_00_02, 20'h0_00_03, 20'h0_00_04, 20'h0_00_05, 20'h0_00_06,
    20'h1_03_00, 20'h1_03_01, 20'h1_00_01,
    20'h0_00_07, 20'h2_01_00,
    20'h0_00_03, 20'h2_02_00,
    20'h0_00_FF,
    20'h1_05_00, 20'h1_06_00, 20'h1_02_00,
    20'h3_00_05, 20'h2_03_00,
    20'h0_00_06, 20'h2_04_00,
    20'h0_00_02, 20'h2_05_00,
    20'h1_07_00, 20'h1_01_00, 20'h1_04_00, 20'h1_05_00,
    20'h3_00_04, 20'h0_00_05, 20'h2_07_00,
    20'h0_00_07, 20'h0_00_01, 20'h2_08_00,
    20'h0_00_FF
  };

  logic clk, rst_n;
  logic alloc_req, alloc_ready, alloc_vld, alloc_err;
  logic [ASID_W-1:0] alloc_id;
  logic free_req, free_bad;
  logic [ASID_W-1:0] free_id;
  logic flush_req, flush_ack;
  logic [FIELD_W-1:0] rv_id;
  logic [VRN_W-1:0] rv_vrn;
  logic [RID_W-1:0] rv_value;

  int n_cmp = 0, n_bad = 0, n_flush = 0;
  bit finished = 1'b0;

  asid_rr_alloc #(.RID_W(RID_W), .ASID_W(ASID_W), .VRN_W(VRN_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_ready(alloc_ready), .alloc_vld(alloc_vld),
    .alloc_id(alloc_id), .alloc_err(alloc_err),
    .free_req(free_req), .free_id(free_id), .free_bad(free_bad),
    .flush_req(flush_req), .flush_ack(flush_ack),
    .rv_id(rv_id), .rv_vrn(rv_vrn), .rv_value(rv_value)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Flush responder: acknowledges each request after one cycle.
  initial begin
    flush_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && flush_req && !flush_ack) begin
        check(!alloc_ready, "R3 ready low while flushing", alloc_ready, 0);
        flush_ack = 1'b1;
        n_flush++;
      end else begin
        flush_ack = 1'b0;
      end
    end
  end

  task automatic wait_ready();
    for (int g = 0; g < 5000 && !alloc_ready; g++) @(negedge clk);
  endtask

  task automatic do_alloc(output int id, output bit err, output int waitc);
    wait_ready();
    alloc_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
    waitc = 1;
    while (!alloc_vld && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    id  = int'(alloc_id);
    err = alloc_err;
  endtask

  task automatic do_free(input int id, output bit bad);
    free_req = 1'b1;
    free_id  = ASID_W'(id);
    @(negedge clk);
    free_req = 1'b0;
    bad = free_bad;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int id, waitc;
    bit err, bad;
    rst_n = 1'b0; alloc_req = 1'b0; free_req = 1'b0; free_id = '0;
    rv_id = '0; rv_vrn = '0;
    repeat (3) @(negedge clk);
    check(alloc_ready == 1'b1, "R9 reset ready", alloc_ready, 1);
    check(flush_req == 1'b0, "R3 reset flush_req", flush_req, 0);
    check(alloc_vld == 1'b0, "R9 reset alloc_vld", alloc_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] op;
      logic [7:0] arg, exp;
      {op, arg, exp} = VEC[i];
      case (op)
        4'h0, 4'h3: begin
          do_alloc(id, err, waitc);
          if (exp == 8'hFF) begin
            check(err == 1'b1, "R7 error when all live", err, 1);
          end else begin
            check(err == 1'b0, "R7 no error", err, 0);
            check(id == int'(exp), "R2/R4 granted id", id, exp);
            check(id != 0, "R1 nonzero grant", id, 1);
          end
          if (op == 4'h0) check(waitc == 1, "R9 next-cycle response", waitc, 1);
        end
        4'h1: begin
          do_free(int'(arg), bad);
          check(bad == exp[0], "R5/R6 release flag", bad, exp[0]);
        end
        4'h2: begin
          wait_ready();
          check(n_flush == int'(arg), "R3 flush count", n_flush, arg);
        end
        default: ;
      endcase
    end

    // R8 region value
    rv_id = FIELD_W'(15'h1234); rv_vrn = 3'd5;
    @(negedge clk);
    check(rv_value == RID_W'(32'h1234 * 8 + 5), "R8 region value", rv_value, 32'h1234 * 8 + 5);
    rv_id = '1; rv_vrn = 3'd0;
    @(negedge clk);
    check(rv_value == RID_W'((32'h7FFF) * 8), "R8 region value top", rv_value, 32'h7FFF * 8);

    // Mid-run reset: range restarts at 1, live map cleared
    rst_n = 1'b0;
    @(negedge clk);
    check(alloc_ready == 1'b1, "R2 ready after reset", alloc_ready, 1);
    check(flush_req == 1'b0, "R3 no flush after reset", flush_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_free(5, bad);
    check(bad == 1'b1, "R6 release of non-live after reset", bad, 1);
    do_alloc(id, err, waitc);
    check(id == 1 && !err, "R2 first grant after reset", id, 1);
    do_alloc(id, err, waitc);
    check(id == 2, "R2 consecutive grant", id, 2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule